// File: doc/BRIEF.md
# Layered Command Write-Protect Gate

This block sits between a decoded power-management command stream and the register file behind it. For every command write it decides, in the same cycle, whether the target register may take the data. It keeps a 16-bit extended protection word. Most bits of that word each guard one group of command codes. One bit locks the protection word itself, and one bit locks the standard write-protect command. A plain two-bit standard protection level is checked beside the extended word. A write goes ahead only when both layers allow it.

The command stream uses a `cmd_valid` qualifier with no ready signal. The gate takes a command in every cycle where `cmd_valid` is high and never applies back-pressure. The result appears combinationally on `wr_en` or `wr_rej` in that same cycle. A write to code C7h is a write to the protection word, and the word changes on the next clock edge. Reset and the restore event both load the word from `dflt_prot`, which stands in for the stored image. The store-command guard uses a copy of bit 0 taken at those two moments and at no other time.

Top module: `wprot_gate`

## Requirements
- R1: At reset (synchronous, `rst_n` low) `prot_val` loads `dflt_prot` with bit 15 cleared, and the store guard copy loads `dflt_prot[0]`.
- R2: Bit 15 of the protection word always reads 0, and a 1 written to it is dropped.
- R3: While bit 14 is 0, writes to code 10h (standard protect command) and code C7h (protection word) are accepted whatever bit 2 holds, and a C7h write replaces bits 14..0 with the written value.
- R4: While bit 14 is 1, every write to code 10h is rejected.
- R5: While bit 14 is 1 and bit 2 is 0, a C7h write is accepted and the word becomes the old value ORed with the written value, so no set bit ever clears.
- R6: While bits 14 and 2 are both 1, every C7h write is rejected and the word keeps its value.
- R7: A write is rejected when its code belongs to a group whose bit is 1. Bit 13 covers 22h, 28h, 29h, D4h, D6h, D7h and D8h. Bit 12 covers 20h and 21h. Bit 11 covers 24h, 2Bh, 40h, 41h, 44h and 45h. Bit 10 covers 1Bh, 42h, 43h, 4Ah, 51h and 6Bh. Bit 9 covers 46h, 47h, 4Fh and 50h. Bit 8 covers 25h, 26h and 27h. Bit 7 covers 01h. Bit 6 covers 33h, CDh, CFh, D0h, D1h, D2h, D5h, DAh and DBh. Bit 5 covers 55h. Bit 4 covers 02h, 35h, 36h, 60h, 61h, 64h and 65h. Bit 3 covers 99h, 9Ah and 9Bh. Bit 2 covers 0Eh. Bit 1 covers 16h.
- R8: The extended word never blocks a code that is in no group and is not 10h, 15h or C7h.
- R9: A write to code 15h (store) is rejected exactly when the guard copy of bit 0 is 1. Changing the live bit 0 has no effect until the next reset or restore.
- R10: A restore event loads the word from `dflt_prot` (bit 15 cleared) and the guard copy from `dflt_prot[0]`. It takes priority over a C7h write in the same cycle.
- R11: The standard level `std_level` works as follows. 0 allows all codes. 1 allows only 10h and C7h. 2 also allows 01h. 3 also allows 01h, 20h and 21h. A write proceeds only if both the standard level and the extended word allow it.
- R12: While `cmd_valid` is high, exactly one of `wr_en` and `wr_rej` is high in that same cycle. While it is low, both are low. A rejected write never changes the protection word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low (power-on) |
| dflt_prot | input | 16 | Stored protection image, loaded on reset and restore |
| restore_evt | input | 1 | One-cycle restore event |
| std_level | input | 2 | Standard write-protect level |
| cmd_valid | input | 1 | A command write is present this cycle |
| cmd_code | input | 8 | Command code of the write |
| cmd_data | input | 16 | Write data |
| wr_en | output | 1 | Write allowed to the target register |
| wr_rej | output | 1 | Write refused, one cycle per refused command |
| prot_val | output | 16 | Current protection word for readback |

## Verification
A corrupted protection word shows up at `prot_val` one cycle after the edge that caused it. It also shows up as a wrong `wr_en`/`wr_rej` decision on the next write to any code in an affected group. A wrong guard copy of bit 0 is visible only through the outcome of a store-command write. For that reason the bench issues store writes after live bit 0 changes and after each restore. Sticky-lock faults, such as a lost OR merge or a write that gets through while read-only, appear at `prot_val` on the cycle after the offending C7h write.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  localparam int PROT_W    = 16;
  localparam int CODE_W    = 8;
  localparam int RSV_BIT   = 15;
  localparam int LOCK_BIT  = 14;
  localparam int PSK_BIT   = 2;
  localparam int STORE_BIT = 0;
  localparam int GRP_LO    = 1;
  localparam int GRP_HI    = LOCK_BIT - 1;
  // guard vector slots beyond the group bits
  localparam int G_STDWP   = LOCK_BIT;
  localparam int G_EXTWP   = RSV_BIT;

  localparam logic [CODE_W-1:0] C_STDWP = 8'h10;
  localparam logic [CODE_W-1:0] C_EXTWP = 8'hC7;
  localparam logic [CODE_W-1:0] C_OPER  = 8'h01;
  localparam logic [CODE_W-1:0] C_VMODE = 8'h20;
  localparam logic [CODE_W-1:0] C_VCMD  = 8'h21;

  typedef enum logic [1:0] {
    LVL_OPEN = 2'd0,
    LVL_ALL  = 2'd1,
    LVL_OPER = 2'd2,
    LVL_VOUT = 2'd3
  } std_lvl_e;
endpackage

// File: rtl/wprot_cmd_map.sv
module wprot_cmd_map
  import wprot_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int PW = PROT_W
) (
  input  logic [CW-1:0] code,
  output logic [PW-1:0] guard
);
  always_comb begin
    guard = '0;
    case (code)
      8'h22, 8'h28, 8'h29, 8'hD4, 8'hD6, 8'hD7, 8'hD8: guard[13] = 1'b1;
      8'h20, 8'h21:                                    guard[12] = 1'b1;
      8'h24, 8'h2B, 8'h40, 8'h41, 8'h44, 8'h45:        guard[11] = 1'b1;
      8'h1B, 8'h42, 8'h43, 8'h4A, 8'h51, 8'h6B:        guard[10] = 1'b1;
      8'h46, 8'h47, 8'h4F, 8'h50:                      guard[9]  = 1'b1;
      8'h25, 8'h26, 8'h27:                             guard[8]  = 1'b1;
      8'h01:                                           guard[7]  = 1'b1;
      8'h33, 8'hCD, 8'hCF, 8'hD0, 8'hD1, 8'hD2,
      8'hD5, 8'hDA, 8'hDB:                             guard[6]  = 1'b1;
      8'h55:                                           guard[5]  = 1'b1;
      8'h02, 8'h35, 8'h36, 8'h60, 8'h61, 8'h64, 8'h65: guard[4]  = 1'b1;
      8'h99, 8'h9A, 8'h9B:                             guard[3]  = 1'b1;
      8'h0E:                                           guard[2]  = 1'b1;
      8'h16:                                           guard[1]  = 1'b1;
      8'h15:                                           guard[STORE_BIT] = 1'b1;
      C_STDWP:                                         guard[G_STDWP] = 1'b1;
      C_EXTWP:                                         guard[G_EXTWP] = 1'b1;
      default:                                         guard = '0;
    endcase
  end
endmodule

// File: rtl/wprot_std_filter.sv
module wprot_std_filter
  import wprot_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic [CW-1:0] code,
  input  logic [1:0]    level,
  output logic          allow
);
  logic is_prot, is_oper, is_vout;

  always_comb begin
    is_prot = (code == C_STDWP) || (code == C_EXTWP);
    is_oper = (code == C_OPER);
    is_vout = (code == C_VMODE) || (code == C_VCMD);
    unique case (std_lvl_e'(level))
      LVL_OPEN: allow = 1'b1;
      LVL_ALL:  allow = is_prot;
      LVL_OPER: allow = is_prot || is_oper;
      LVL_VOUT: allow = is_prot || is_oper || is_vout;
      default:  allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/wprot_ext_reg.sv
module wprot_ext_reg
  import wprot_pkg::*;
#(
  parameter int PW = PROT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] dflt,
  input  logic          restore,
  input  logic          wr_acc,
  input  logic [PW-1:0] wr_data,
  output logic [PW-1:0] prot_q,
  output logic          store_shadow_q
);
  localparam logic [PW-1:0] KEEP_MASK = ~(PW'(1) << RSV_BIT);

  logic [PW-1:0] wr_clean, nxt_val;

  always_comb begin
    wr_clean = wr_data & KEEP_MASK;
    // sticky merge while the self-lock bit is set
    nxt_val  = prot_q[LOCK_BIT] ? (prot_q | wr_clean) : wr_clean;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restore) begin
      prot_q         <= dflt & KEEP_MASK;
      store_shadow_q <= dflt[STORE_BIT];
    end else if (wr_acc) begin
      prot_q         <= nxt_val;
    end
  end
endmodule

// File: rtl/wprot_gate.sv
module wprot_gate
  import wprot_pkg::*;
#(
  parameter int PW = PROT_W,
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] dflt_prot,
  input  logic          restore_evt,
  input  logic [1:0]    std_level,
  input  logic          cmd_valid,
  input  logic [CW-1:0] cmd_code,
  input  logic [PW-1:0] cmd_data,
  output logic          wr_en,
  output logic          wr_rej,
  output logic [PW-1:0] prot_val
);
  logic [PW-1:0] guard;
  logic [PW-1:0] hit;
  logic          std_ok, ext_ok, allow, shadow;

  wprot_cmd_map #(.CW(CW), .PW(PW)) u_map (
    .code  (cmd_code),
    .guard (guard)
  );

  wprot_std_filter #(.CW(CW)) u_std (
    .code  (cmd_code),
    .level (std_level),
    .allow (std_ok)
  );

  wprot_ext_reg #(.PW(PW)) u_reg (
    .clk            (clk),
    .rst_n          (rst_n),
    .dflt           (dflt_prot),
    .restore        (restore_evt),
    .wr_acc         (wr_en && guard[G_EXTWP]),
    .wr_data        (cmd_data),
    .prot_q         (prot_val),
    .store_shadow_q (shadow)
  );

  for (genvar g = GRP_LO; g <= GRP_HI; g++) begin : g_grp
    assign hit[g] = guard[g] & prot_val[g];
  end
  assign hit[STORE_BIT] = guard[STORE_BIT] & shadow;
  assign hit[G_STDWP]   = guard[G_STDWP] & prot_val[LOCK_BIT];
  assign hit[G_EXTWP]   = guard[G_EXTWP] & prot_val[LOCK_BIT] & prot_val[PSK_BIT];

  assign ext_ok = ~|hit;
  assign allow  = ext_ok & std_ok;
  assign wr_en  = cmd_valid & allow;
  assign wr_rej = cmd_valid & ~allow;
endmodule

// File: rtl/wprot_gate_chk.sv
module wprot_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] dflt_prot,
  input logic        restore_evt,
  input logic [1:0]  std_level,
  input logic        cmd_valid,
  input logic [7:0]  cmd_code,
  input logic [15:0] cmd_data,
  input logic        wr_en,
  input logic        wr_rej,
  input logic [15:0] prot_val
);
  // R2
  rsv_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_val[15]);

  // R4
  stdwp_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 8'h10 && prot_val[14]) |-> wr_rej);

  // R5
  or_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_val[14] && !restore_evt) |=> ((prot_val | $past(prot_val)) == prot_val));

  // R6
  ro_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_val[14] && prot_val[2] && !restore_evt) |=> $stable(prot_val));

  // R10
  restore_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_evt |=> (prot_val == ($past(dflt_prot) & 16'h7FFF)));

  // R12
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $onehot({wr_en, wr_rej}));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> !(wr_en || wr_rej));

  // R12
  rej_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 8'hC7 && wr_rej && !restore_evt) |=> $stable(prot_val));
endmodule

bind wprot_gate wprot_gate_chk u_chk (.*);

// File: tb/sim_wprot_gate.sv
`timescale 1ns/100ps
module sim_wprot_gate;
  typedef struct {
    logic        en;
    logic        rej;
    logic [15:0] pv;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] dflt_prot = 16'h8001;
  logic        restore_evt = 1'b0;
  logic [1:0]  std_level = 2'd0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = 8'h00;
  logic [15:0] cmd_data = 16'h0000;
  logic        wr_en, wr_rej;
  logic [15:0] prot_val;

  int   n_chk = 0;
  int   n_bad = 0;
  exp_t sbq[$];
  logic [15:0] m_prot;
  logic        m_shadow;

  always #2.5 clk = ~clk;

  wprot_gate u0 (
    .clk(clk), .rst_n(rst_n), .dflt_prot(dflt_prot), .restore_evt(restore_evt),
    .std_level(std_level), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_data(cmd_data), .wr_en(wr_en), .wr_rej(wr_rej), .prot_val(prot_val)
  );

  // group bit of a code per R7, -1 when in no group
  function automatic int grp_of(input logic [7:0] c);
    case (c)
      8'h22, 8'h28, 8'h29, 8'hD4, 8'hD6, 8'hD7, 8'hD8: return 13;
      8'h20, 8'h21: return 12;
      8'h24, 8'h2B, 8'h40, 8'h41, 8'h44, 8'h45: return 11;
      8'h1B, 8'h42, 8'h43, 8'h4A, 8'h51, 8'h6B: return 10;
      8'h46, 8'h47, 8'h4F, 8'h50: return 9;
      8'h25, 8'h26, 8'h27: return 8;
      8'h01: return 7;
      8'h33, 8'hCD, 8'hCF, 8'hD0, 8'hD1, 8'hD2, 8'hD5, 8'hDA, 8'hDB: return 6;
      8'h55: return 5;
      8'h02, 8'h35, 8'h36, 8'h60, 8'h61, 8'h64, 8'h65: return 4;
      8'h99, 8'h9A, 8'h9B: return 3;
      8'h0E: return 2;
      8'h16: return 1;
      default: return -1;
    endcase
  endfunction

  function automatic logic model_ok(input logic [7:0] c, input logic [1:0] l);
    logic sok, eok;
    int   g;
    // R11 standard layer
    case (l)
      2'd0: sok = 1'b1;
      2'd1: sok = (c == 8'h10 || c == 8'hC7);
      2'd2: sok = (c == 8'h10 || c == 8'hC7 || c == 8'h01);
      default: sok = (c == 8'h10 || c == 8'hC7 || c == 8'h01 || c == 8'h20 || c == 8'h21);
    endcase
    g   = grp_of(c);
    eok = 1'b1;
    if (g > 0 && m_prot[g]) eok = 1'b0;                          // R7
    if (c == 8'h15 && m_shadow) eok = 1'b0;                      // R9
    if (c == 8'h10 && m_prot[14]) eok = 1'b0;                    // R4
    if (c == 8'hC7 && m_prot[14] && m_prot[2]) eok = 1'b0;       // R6
    return sok && eok;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  task automatic step(input logic v, input logic [7:0] c, input logic [15:0] d,
                      input logic rs, input logic [1:0] l, input string tag);
    exp_t e;
    logic ok;
    @(negedge clk);
    cmd_valid = v; cmd_code = c; cmd_data = d; restore_evt = rs; std_level = l;
    ok    = model_ok(c, l);
    e.en  = v && ok;
    e.rej = v && !ok;
    e.pv  = m_prot;
    e.tag = tag;
    sbq.push_back(e);
    if (rs) begin
      m_prot   = dflt_prot & 16'h7FFF;
      m_shadow = dflt_prot[0];
    end else if (v && ok && c == 8'hC7) begin
      m_prot = m_prot[14] ? (m_prot | (d & 16'h7FFF)) : (d & 16'h7FFF);
    end
  endtask

  // monitor: compare results half a clock away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        n_chk++;
        if (wr_en !== e.en) begin
          n_bad++;
          $display("FAIL %s wr_en actual %b expected %b", e.tag, wr_en, e.en);
        end
        n_chk++;
        if (wr_rej !== e.rej) begin
          n_bad++;
          $display("FAIL %s wr_rej actual %b expected %b", e.tag, wr_rej, e.rej);
        end
        n_chk++;
        if (prot_val !== e.pv) begin
          n_bad++;
          $display("FAIL %s prot_val actual %h expected %h", e.tag, prot_val, e.pv);
        end
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    n_bad++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n    = 1'b1;
    m_prot   = 16'h0001;   // R1: bit 15 of default dropped
    m_shadow = 1'b1;
    step(0, 8'h00, 16'h0000, 0, 0, "R1");
    step(1, 8'h15, 16'h0000, 0, 0, "R9");
    step(1, 8'hC7, 16'h8000, 0, 0, "R2");
    step(0, 8'h00, 16'h0000, 0, 0, "R2");
    step(1, 8'h15, 16'h0000, 0, 0, "R9");   // live bit 0 now clear, copy still set
    dflt_prot = 16'h0000;
    step(0, 8'h00, 16'h0000, 1, 0, "R10");
    step(1, 8'h15, 16'h0000, 0, 0, "R9");
    step(1, 8'hC7, 16'h0004, 0, 0, "R3");
    step(1, 8'h0E, 16'h0000, 0, 0, "R7");
    step(1, 8'hC7, 16'h0000, 0, 0, "R3");
    step(1, 8'h10, 16'h0055, 0, 0, "R3");
    step(1, 8'hC7, 16'h2000, 0, 0, "R7");
    step(1, 8'h22, 16'h0001, 0, 0, "R7");
    step(1, 8'h33, 16'h0001, 0, 0, "R7");
    step(1, 8'h03, 16'h0001, 0, 0, "R8");
    step(1, 8'h33, 16'h0001, 0, 1, "R11");
    step(1, 8'h10, 16'h0001, 0, 1, "R11");
    step(1, 8'h01, 16'h0001, 0, 2, "R11");
    step(1, 8'h21, 16'h0001, 0, 2, "R11");
    step(1, 8'h21, 16'h0001, 0, 3, "R11");
    step(1, 8'h24, 16'h0001, 0, 3, "R11");
    step(1, 8'h22, 16'h0001, 0, 3, "R11");
    step(1, 8'hC7, 16'hC080, 0, 0, "R5");
    step(1, 8'h10, 16'h0000, 0, 0, "R4");
    step(1, 8'h01, 16'h0000, 0, 0, "R7");
    step(1, 8'hC7, 16'h0000, 0, 0, "R5");
    step(1, 8'hC7, 16'h0100, 0, 0, "R5");
    step(1, 8'h26, 16'h0000, 0, 0, "R7");
    step(1, 8'hC7, 16'h0004, 0, 0, "R5");
    step(1, 8'hC7, 16'hFFFF, 0, 0, "R6");
    step(0, 8'h00, 16'h0000, 0, 0, "R12");
    step(1, 8'hC7, 16'h0000, 0, 0, "R6");
    dflt_prot = 16'h0001;
    step(1, 8'hC7, 16'h0002, 1, 0, "R10");
    step(0, 8'h00, 16'h0000, 0, 0, "R10");
    step(1, 8'h15, 16'h0000, 0, 0, "R9");
    step(1, 8'hC7, 16'h0002, 1, 0, "R10");
    step(0, 8'h00, 16'h0000, 0, 0, "R12");
    step(1, 8'h03, 16'h0000, 0, 0, "R8");
    step(0, 8'h00, 16'h0000, 0, 0, "R12");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule